// File: doc/BRIEF.md
# Memory Playback Burst and Packet Engine

This block plays stored sample data back out of memory. Software queues play commands, each naming a start address, a length in bytes, a timestamp and a flag that says whether the playback is timed. The engine takes one command at a time from a small queue. It walks the region with read-address requests and passes the returned read data to a streaming output. The output is split into packets of a configured size, each closed with a last flag, and an end-of-burst marker flags the final word of the playback.

The size of a read request follows only the memory rules: a request covers at most 2048 bytes and never crosses a 4096-byte boundary. The packet size comes only from the words-per-packet setting. A packet can therefore span several requests, and one request can close one packet and open the next. A small read port returns the free space in the command queue, the address of the next read request and a sticky flag that records dropped commands.

Top module: `memory_playback_engine`

## Requirements
- R1: With W equal to the words-per-packet value taken when a playback starts (a value of 0 counts as 1), out_last is high on every W-th word of a playback and on its final word. Every packet holds W words except the last one, which holds the remainder.
- R2: Each read request covers at most 2048 bytes, and mem_ar_len is the beat count minus one. Successive requests cover the playback contiguously from its base address, and each request is as long as R2 and R3 allow.
- R3: No read request crosses a 4096-byte address boundary. A region that spans a boundary is split exactly there.
- R4: The base, length, timestamp and timed flag are captured in the cycle cmd_valid is high, so later changes on those inputs have no effect. The byte length is rounded up to whole data words. Data words leave in address order, unchanged.
- R5: With reg_sel = 0, reg_rdata gives the number of free command queue entries: the depth (4 by default) minus the commands queued and not yet started.
- R6: With reg_sel = 1, reg_rdata gives the address of the next read request of the active playback. Once all requests are issued it holds base plus length in words times the word size.
- R7: In a timed playback, every word of the first packet has out_has_ts = 1 and out_ts equal to the command timestamp. Every other word, and every word of an untimed playback, has out_has_ts = 0 and out_ts = 0.
- R8: A command offered while the queue is full is dropped, and bit 0 of reg_rdata with reg_sel = 2 becomes 1 and stays 1 until reset.
- R9: Packet boundaries do not depend on request boundaries. A packet may take words from several requests.
- R10: The final word of a playback carries both out_last and out_eob, and out_eob is high on no other word. A queued command starts in the same cycle, so its first read request is accepted in the next cycle when the memory is ready.
- R11: mem_r_ready is low whenever out_ready is low, out_valid is high only with mem_r_valid, and no word is lost or duplicated under backpressure on either side.
- R12: After reset, mem_ar_valid and out_valid are low, the queue reports all entries free, the drop flag is 0 and the play address is 0. A read request keeps its address and length until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Offers one play command for a single cycle |
| cmd_base | input | MEM_ADDR_W | Start byte address, word aligned |
| cmd_bytes | input | MEM_ADDR_W | Playback length in bytes, nonzero |
| cmd_ts | input | TS_W | Timestamp for the first packet |
| cmd_timed | input | 1 | Attach the timestamp when 1 |
| cfg_words_per_pkt | input | PKT_W | Words per output packet |
| reg_sel | input | 2 | Read select: 0 free entries, 1 play address, 2 drop flag |
| reg_rdata | output | MEM_ADDR_W | Read data for reg_sel |
| mem_ar_valid | output | 1 | Read request valid |
| mem_ar_ready | input | 1 | Read request accepted |
| mem_ar_addr | output | MEM_ADDR_W | Read request byte address |
| mem_ar_len | output | 8 | Read request beats minus one |
| mem_r_valid | input | 1 | Read data valid |
| mem_r_ready | output | 1 | Read data accepted |
| mem_r_data | input | DATA_W | Read data word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of a packet |
| out_eob | output | 1 | Final word of a playback |
| out_has_ts | output | 1 | Word belongs to a timestamped first packet |
| out_ts | output | TS_W | Timestamp, zero when out_has_ts is low |

## Verification
The case that is hardest to reach from the ports is a full queue behind an active playback, followed by the handover from one command to the next. A full queue needs the memory to stall while commands arrive. The bench holds off request acceptance and read data, queues one command that starts at once and four that fill the queue, then offers one more that must be dropped. Once the memory is released it measures the cycle of each end-of-burst word against the cycle of the next accepted request. Regions that start just below a 4096-byte boundary, together with packet sizes that do not divide the 256-word request cap, make packet boundaries and request boundaries fall apart.

// File: rtl/playback_pkg.sv
// Shared constants and register select codes for the playback engine.
// Assumes byte addressing and a memory protocol with a 4 KiB boundary rule.
package playback_pkg;
    localparam int BURST_MAX_BYTES = 2048;
    localparam int BOUNDARY_BYTES  = 4096;

    typedef enum logic [1:0] {
        RSEL_FREE = 2'd0,
        RSEL_POS  = 2'd1,
        RSEL_FLAG = 2'd2
    } rsel_e;
endpackage

// File: rtl/play_cmd_fifo.sv
// Play command queue: a small synchronous FIFO that holds flattened commands.
// Assumes DEPTH is a power of two and at least 2. Push on full and pop on
// empty are blocked by the caller.
module play_cmd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign rdata = mem[rptr];

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/play_burst_gen.sv
// Read request generator: walks one playback region in requests that are as
// long as possible, capped at BURST_MAX_BYTES and cut at each 4 KiB boundary.
// Assumes a word-aligned base and a nonzero word count at start.
module play_burst_gen
    import playback_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BSH       = 3,
    parameter int MAX_BEATS = 256,
    parameter int ALEN_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] start_words,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [ALEN_W-1:0] ar_len,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int BND_BITS = $clog2(BOUNDARY_BYTES);
    localparam int RW       = BND_BITS + 1;

    logic              busy;
    logic [ADDR_W-1:0] addr, words_left;
    logic [RW-1:0]     room, room_w, cap_w, beats;

    // Size of the next request: the smallest of remaining, cap and room.
    always_comb begin
        room   = RW'(BOUNDARY_BYTES) - RW'(addr[BND_BITS-1:0]);
        room_w = room >> BSH;
        cap_w  = (words_left < ADDR_W'(MAX_BEATS)) ? RW'(words_left) : RW'(MAX_BEATS);
        beats  = (cap_w < room_w) ? cap_w : room_w;
    end

    assign ar_valid = busy;
    assign ar_addr  = addr;
    assign ar_len   = ALEN_W'(beats - RW'(1));
    assign cur_addr = addr;

    // Load a region on start, step past each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            addr       <= '0;
            words_left <= '0;
        end else if (start) begin
            busy       <= 1'b1;
            addr       <= start_addr;
            words_left <= start_words;
        end else if (busy && ar_ready) begin
            addr       <= addr + (ADDR_W'(beats) << BSH);
            words_left <= words_left - ADDR_W'(beats);
            busy       <= (words_left != ADDR_W'(beats));
        end
    end
endmodule

// File: rtl/play_pkt_framer.sv
// Output framer: passes read words to the stream with no buffering, cuts
// packets every W words, flags the final word and stamps the first packet.
// Assumes read data arrives in address order and is held while not accepted.
module play_pkt_framer #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int TS_W   = 64,
    parameter int PKT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_words,
    input  logic [TS_W-1:0]   start_ts,
    input  logic              start_timed,
    input  logic [PKT_W-1:0]  start_wpp,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [DATA_W-1:0] r_data,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [DATA_W-1:0] o_data,
    output logic              o_last,
    output logic              o_eob,
    output logic              o_has_ts,
    output logic [TS_W-1:0]   o_ts,
    output logic              done
);
    logic              active, first, timed;
    logic [ADDR_W-1:0] words_left;
    logic [PKT_W-1:0]  pkt_cnt, wpp;
    logic [TS_W-1:0]   ts;
    logic              beat;

    assign o_valid  = active && r_valid;
    assign r_ready  = active && o_ready;
    assign o_data   = r_data;
    assign o_eob    = (words_left == ADDR_W'(1));
    assign o_last   = o_eob || (pkt_cnt == wpp - PKT_W'(1));
    assign o_has_ts = timed && first;
    assign o_ts     = o_has_ts ? ts : '0;
    assign beat     = o_valid && o_ready;
    assign done     = beat && o_eob;

    // Capture a playback on start, then count words and packets per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            first      <= 1'b0;
            timed      <= 1'b0;
            words_left <= '0;
            pkt_cnt    <= '0;
            wpp        <= PKT_W'(1);
            ts         <= '0;
        end else if (start) begin
            active     <= 1'b1;
            first      <= 1'b1;
            timed      <= start_timed;
            words_left <= start_words;
            pkt_cnt    <= '0;
            wpp        <= (start_wpp == '0) ? PKT_W'(1) : start_wpp;
            ts         <= start_ts;
        end else if (beat) begin
            words_left <= words_left - ADDR_W'(1);
            if (o_eob) begin
                active <= 1'b0;
            end else if (o_last) begin
                pkt_cnt <= '0;
                first   <= 1'b0;
            end else begin
                pkt_cnt <= pkt_cnt + PKT_W'(1);
            end
        end
    end
endmodule

// File: rtl/memory_playback_engine.sv
// Playback engine top: queues play commands, runs one at a time through the
// request generator and the output framer, and serves a small read port.
// Assumes word-aligned bases, nonzero lengths and in-order read data.
module memory_playback_engine
    import playback_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int MEM_ADDR_W = 32,
    parameter int TS_W       = 64,
    parameter int PKT_W      = 16,
    parameter int CMD_DEPTH  = 4,
    parameter int ADDR_W     = MEM_ADDR_W,
    localparam int BYTES     = DATA_W / 8,
    localparam int BSH       = $clog2(BYTES),
    localparam int MAX_BEATS = BURST_MAX_BYTES / BYTES,
    localparam int ALEN_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_bytes,
    input  logic [TS_W-1:0]   cmd_ts,
    input  logic              cmd_timed,
    input  logic [PKT_W-1:0]  cfg_words_per_pkt,
    input  logic [1:0]        reg_sel,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_ar_valid,
    input  logic              mem_ar_ready,
    output logic [ADDR_W-1:0] mem_ar_addr,
    output logic [ALEN_W-1:0] mem_ar_len,
    input  logic              mem_r_valid,
    output logic              mem_r_ready,
    input  logic [DATA_W-1:0] mem_r_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_eob,
    output logic              out_has_ts,
    output logic [TS_W-1:0]   out_ts
);
    localparam int CMD_W = 2 * ADDR_W + TS_W + 1;
    localparam int CNT_W = $clog2(CMD_DEPTH + 1);

    logic              fifo_push, fifo_pop, fifo_empty, fifo_full, done, act, ovf_q;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [ADDR_W-1:0] words_in, hd_base, hd_words, play_pos;
    logic [TS_W-1:0]   hd_ts;
    logic              hd_timed;
    logic [CMD_W-1:0]  fifo_wdata, fifo_rdata;

    // Round the byte length up to whole words at capture.
    assign words_in   = (cmd_bytes >> BSH) + ADDR_W'(|cmd_bytes[BSH-1:0]);
    assign fifo_wdata = {cmd_base, words_in, cmd_ts, cmd_timed};
    assign fifo_push  = cmd_valid && !fifo_full;
    assign fifo_pop   = !fifo_empty && (!act || done);
    assign {hd_base, hd_words, hd_ts, hd_timed} = fifo_rdata;

    play_cmd_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(fifo_wdata),
        .pop(fifo_pop), .rdata(fifo_rdata), .empty(fifo_empty),
        .full(fifo_full), .count(fifo_cnt)
    );

    play_burst_gen #(.ADDR_W(ADDR_W), .BSH(BSH), .MAX_BEATS(MAX_BEATS), .ALEN_W(ALEN_W)) gen_i (
        .clk(clk), .rst_n(rst_n), .start(fifo_pop), .start_addr(hd_base),
        .start_words(hd_words), .ar_valid(mem_ar_valid), .ar_ready(mem_ar_ready),
        .ar_addr(mem_ar_addr), .ar_len(mem_ar_len), .cur_addr(play_pos)
    );

    play_pkt_framer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .PKT_W(PKT_W)) frm_i (
        .clk(clk), .rst_n(rst_n), .start(fifo_pop), .start_words(hd_words),
        .start_ts(hd_ts), .start_timed(hd_timed), .start_wpp(cfg_words_per_pkt),
        .r_valid(mem_r_valid), .r_ready(mem_r_ready), .r_data(mem_r_data),
        .o_valid(out_valid), .o_ready(out_ready), .o_data(out_data),
        .o_last(out_last), .o_eob(out_eob), .o_has_ts(out_has_ts),
        .o_ts(out_ts), .done(done)
    );

    // Track the active playback and the sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (fifo_pop)  act <= 1'b1;
            else if (done) act <= 1'b0;
            if (cmd_valid && fifo_full) ovf_q <= 1'b1;
        end
    end

    // Read port multiplexer.
    always_comb begin
        case (rsel_e'(reg_sel))
            RSEL_FREE: reg_rdata = ADDR_W'(CMD_DEPTH) - ADDR_W'(fifo_cnt);
            RSEL_POS:  reg_rdata = play_pos;
            RSEL_FLAG: reg_rdata = ADDR_W'(ovf_q);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/playback_chk.sv
// Protocol checker for the playback engine, attached by bind below.
// Assumes the same widths as the engine it watches.
module playback_chk #(
    parameter int ADDR_W = 32,
    parameter int ALEN_W = 8,
    parameter int BSH    = 3,
    parameter int CNT_W  = 3,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ar_valid,
    input logic              mem_ar_ready,
    input logic [ADDR_W-1:0] mem_ar_addr,
    input logic [ALEN_W-1:0] mem_ar_len,
    input logic              mem_r_valid,
    input logic              mem_r_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic              out_eob,
    input logic              out_has_ts,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              ovf_q
);
    // R12: a pending request holds its fields until accepted
    assert_ar_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ar_valid && !mem_ar_ready |=> mem_ar_valid && $stable(mem_ar_addr) && $stable(mem_ar_len));

    // R3: request end stays inside its 4 KiB page
    assert_no_4k_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ar_valid |-> (32'(mem_ar_addr[11:0]) + ((32'(mem_ar_len) + 32'd1) << BSH)) <= 32'd4096);

    // R11: no read data taken while the output stalls
    assert_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !mem_r_ready);

    // R11: output only presents words the memory offers
    assert_valid_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mem_r_valid);

    // R10: end of playback always closes a packet
    assert_eob_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eob |-> out_last);

    // R7: after the first packet closes mid playback, no timestamp follows
    assert_ts_first_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last && !out_eob |=> !out_has_ts);

    // R8: drop flag is sticky
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R5: queue occupancy never exceeds its depth
    assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));
endmodule

bind memory_playback_engine playback_chk #(
    .ADDR_W(ADDR_W), .ALEN_W(ALEN_W), .BSH(BSH), .CNT_W(CNT_W), .DEPTH(CMD_DEPTH)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_ar_valid(mem_ar_valid), .mem_ar_ready(mem_ar_ready),
    .mem_ar_addr(mem_ar_addr), .mem_ar_len(mem_ar_len), .mem_r_valid(mem_r_valid),
    .mem_r_ready(mem_r_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_eob(out_eob), .out_has_ts(out_has_ts),
    .fifo_cnt(fifo_cnt), .ovf_q(ovf_q)
);

// File: tb/memory_playback_engine_tb_top.sv
`timescale 1ns/1ps
// Bench: table of playback vectors, then directed reset and queue tests.
module memory_playback_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_base = '0, cmd_bytes = '0;
    logic [63:0] cmd_ts = '0;
    logic        cmd_timed = 1'b0;
    logic [15:0] cfg_wpp = 16'd1;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_rdata;
    logic        ar_valid, ar_ready, r_valid, r_ready;
    logic [31:0] ar_addr;
    logic [7:0]  ar_len;
    logic [63:0] r_data, o_data, o_ts;
    logic        o_valid, o_ready, o_last, o_eob, o_has_ts;

    // stall controls, driven from the main initial block
    logic ar_hold = 1'b0, mem_en = 1'b1, bp = 1'b0;
    int   ph = 0;
    int   checks = 0, errors = 0;

    always #10 clk = ~clk;

    memory_playback_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
        .cmd_bytes(cmd_bytes), .cmd_ts(cmd_ts), .cmd_timed(cmd_timed),
        .cfg_words_per_pkt(cfg_wpp), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
        .mem_ar_valid(ar_valid), .mem_ar_ready(ar_ready), .mem_ar_addr(ar_addr),
        .mem_ar_len(ar_len), .mem_r_valid(r_valid), .mem_r_ready(r_ready),
        .mem_r_data(r_data), .out_valid(o_valid), .out_ready(o_ready),
        .out_data(o_data), .out_last(o_last), .out_eob(o_eob),
        .out_has_ts(o_has_ts), .out_ts(o_ts)
    );

    // Memory model and logs (all updated with nonblocking assignments).
    logic [31:0] mq_addr [256];
    int          mq_beats [256];
    int          mh = 0, mt = 0, moff = 0, cyc = 0, beat_n = 0, ar_n = 0, bp_viol = 0;
    logic [63:0] lg_data [4096];
    logic [63:0] lg_ts [4096];
    bit          lg_last [4096], lg_eob [4096], lg_hts [4096];
    int          lg_cyc [4096];
    logic [31:0] al_addr [256];
    int          al_beats [256], al_cyc [256];

    always @(negedge clk) ph <= ph + 1;
    assign ar_ready = !ar_hold && (!bp || ph[0]);
    assign o_ready  = !bp || (ph % 3 != 0);
    assign r_valid  = mem_en && (mh != mt);
    assign r_data   = 64'(mq_addr[mh[7:0]]) + 64'(moff * 8);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!o_ready && r_ready) bp_viol <= bp_viol + 1;
        if (ar_valid && ar_ready) begin
            mq_addr[mt[7:0]]  <= ar_addr;
            mq_beats[mt[7:0]] <= int'(ar_len) + 1;
            mt <= mt + 1;
            al_addr[ar_n[7:0]]  <= ar_addr;
            al_beats[ar_n[7:0]] <= int'(ar_len) + 1;
            al_cyc[ar_n[7:0]]   <= cyc;
            ar_n <= ar_n + 1;
        end
        if (r_valid && r_ready) begin
            if (moff + 1 == mq_beats[mh[7:0]]) begin
                moff <= 0;
                mh   <= mh + 1;
            end else begin
                moff <= moff + 1;
            end
        end
        if (o_valid && o_ready) begin
            lg_data[beat_n[11:0]] <= o_data;
            lg_ts[beat_n[11:0]]   <= o_ts;
            lg_last[beat_n[11:0]] <= o_last;
            lg_eob[beat_n[11:0]]  <= o_eob;
            lg_hts[beat_n[11:0]]  <= o_has_ts;
            lg_cyc[beat_n[11:0]]  <= cyc;
            beat_n <= beat_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] b, input logic [31:0] n, input logic [63:0] t,
                        input logic tm);
        @(negedge clk);
        cmd_base = b; cmd_bytes = n; cmd_ts = t; cmd_timed = tm; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        // R4: scramble the inputs after capture
        cmd_base = 32'hDEAD_BEE0; cmd_bytes = 32'h7777; cmd_ts = '1; cmd_timed = ~tm;
    endtask

    task automatic read_reg(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_beats(input int target);
        while (beat_n < target) @(negedge clk);
    endtask

    // Vector table: base, bytes, words-per-packet, timed, backpressure.
    localparam int NV = 5;
    localparam int unsigned V_BASE  [NV] = '{32'h0000_0000, 32'h0000_0F80, 32'h0000_2000,
                                            32'h0000_3C00, 32'h0000_5008};
    localparam int unsigned V_BYTES [NV] = '{60, 512, 4096, 4096, 8};
    localparam int unsigned V_WPP   [NV] = '{3, 16, 100, 0, 4};
    localparam bit          V_TIMED [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam bit          V_BP    [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

    task automatic verify_vec(input int k, input int b0, input int a0);
        int words, w, bad, addr, rem, room, ex;
        logic [63:0] ts, exp_ts;
        bit exp_last, exp_hts;
        words = (V_BYTES[k] + 7) / 8;
        w     = (V_WPP[k] == 0) ? 1 : int'(V_WPP[k]);
        ts    = 64'h1000_0000_0000_0000 + 64'(k);
        check(beat_n - b0 == words, "R4 R11 word count", longint'(beat_n - b0), longint'(words));
        bad = -1;
        for (int i = 0; i < words; i++)
            if (bad < 0 && lg_data[(b0 + i) % 4096] != 64'(V_BASE[k]) + 64'(i * 8)) bad = i;
        check(bad < 0, "R4 R11 data order", (bad < 0) ? 0 : lg_data[(b0 + bad) % 4096],
              (bad < 0) ? 0 : 64'(V_BASE[k]) + 64'(bad * 8));
        bad = -1;
        for (int i = 0; i < words; i++) begin
            exp_last = ((i % w) == w - 1) || (i == words - 1);
            if (bad < 0 && lg_last[(b0 + i) % 4096] != exp_last) bad = i;
        end
        check(bad < 0, "R1 R9 packet last", longint'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        bad = -1;
        for (int i = 0; i < words; i++)
            if (bad < 0 && lg_eob[(b0 + i) % 4096] != (i == words - 1)) bad = i;
        check(bad < 0, "R10 eob position", longint'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        bad = -1;
        for (int i = 0; i < words; i++) begin
            exp_hts = V_TIMED[k] && (i < w);
            exp_ts  = exp_hts ? ts : 64'd0;
            if (bad < 0 && (lg_hts[(b0 + i) % 4096] != exp_hts || lg_ts[(b0 + i) % 4096] != exp_ts))
                bad = i;
        end
        check(bad < 0, "R7 timestamp", longint'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        addr = int'(V_BASE[k]); rem = words; bad = -1;
        for (int j = a0; j < ar_n; j++) begin
            room = (4096 - (addr % 4096)) / 8;
            ex = (rem < 256) ? rem : 256;
            if (room < ex) ex = room;
            if (bad < 0 && (al_addr[j % 256] != 32'(addr) || al_beats[j % 256] != ex)) bad = j - a0;
            addr += ex * 8; rem -= ex;
        end
        check(bad < 0 && rem == 0, "R2 request sizing", longint'(rem), 0);
        bad = -1;
        for (int j = a0; j < ar_n; j++)
            if (bad < 0 && (int'(al_addr[j % 256] % 4096) + al_beats[j % 256] * 8 > 4096
                            || al_beats[j % 256] * 8 > 2048)) bad = j - a0;
        check(bad < 0, "R3 boundary", longint'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        check(bp_viol == 0, "R11 ready under stall", longint'(bp_viol), 0);
    endtask

    initial begin
        logic [31:0] v;
        int b0, a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        @(negedge clk);
        check(!o_valid && !ar_valid, "R12 idle after reset", {o_valid, ar_valid}, 0);
        read_reg(2'd0, v); check(v == 32'd4, "R12 R5 free after reset", v, 4);
        read_reg(2'd2, v); check(v == 32'd0, "R12 R8 flag after reset", v, 0);
        read_reg(2'd1, v); check(v == 32'd0, "R12 R6 position after reset", v, 0);

        // Table-driven playbacks
        for (int k = 0; k < NV; k++) begin
            bp = V_BP[k];
            cfg_wpp = 16'(V_WPP[k]);
            b0 = beat_n; a0 = ar_n;
            push(V_BASE[k], V_BYTES[k], 64'h1000_0000_0000_0000 + 64'(k), V_TIMED[k]);
            wait_beats(b0 + (int'(V_BYTES[k]) + 7) / 8);
            repeat (8) @(negedge clk);
            verify_vec(k, b0, a0);
            read_reg(2'd1, v);
            check(v == V_BASE[k] + ((V_BYTES[k] + 7) / 8) * 8, "R6 position after playback", v,
                  V_BASE[k] + ((V_BYTES[k] + 7) / 8) * 8);
        end

        // Directed: full queue, drop, and handover timing
        bp = 1'b0; ar_hold = 1'b1; mem_en = 1'b0; cfg_wpp = 16'd4;
        b0 = beat_n; a0 = ar_n;
        push(32'h8000, 32, 64'h55, 1'b0);
        repeat (2) @(negedge clk);
        read_reg(2'd1, v); check(v == 32'h8000, "R6 position while stalled", v, 32'h8000);
        read_reg(2'd0, v); check(v == 32'd4, "R5 free after start", v, 4);
        for (int i = 1; i < 5; i++) push(32'h8000 + 32'(i) * 32'h1000, 32, 64'h55, 1'b0);
        read_reg(2'd0, v); check(v == 32'd0, "R5 free when full", v, 0);
        read_reg(2'd2, v); check(v == 32'd0, "R8 flag before drop", v, 0);
        push(32'hF000, 32, 64'h55, 1'b0);
        read_reg(2'd2, v); check(v == 32'd1, "R8 flag after drop", v, 1);
        read_reg(2'd0, v); check(v == 32'd0, "R8 R5 free after drop", v, 0);
        ar_hold = 1'b0; mem_en = 1'b1;
        wait_beats(b0 + 20);
        repeat (30) @(negedge clk);
        check(beat_n - b0 == 20, "R8 dropped command not played", longint'(beat_n - b0), 20);
        check(ar_n - a0 == 5, "R8 request count", longint'(ar_n - a0), 5);
        for (int i = 0; i < 5; i++)
            check(lg_data[(b0 + 4 * i) % 4096] == 64'h8000 + 64'(i) * 64'h1000,
                  "R4 queued base order", lg_data[(b0 + 4 * i) % 4096], 64'h8000 + 64'(i) * 64'h1000);
        for (int i = 0; i < 4; i++)
            check(al_cyc[(a0 + i + 1) % 256] == lg_cyc[(b0 + 4 * i + 3) % 4096] + 1,
                  "R10 next request follows eob", longint'(al_cyc[(a0 + i + 1) % 256]),
                  longint'(lg_cyc[(b0 + 4 * i + 3) % 4096] + 1));
        read_reg(2'd1, v); check(v == 32'hC020, "R6 final position", v, 32'hC020);
        read_reg(2'd2, v); check(v == 32'd1, "R8 flag stays set", v, 1);
        read_reg(2'd0, v); check(v == 32'd4, "R5 free after drain", v, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule